// File: doc/BRIEF.md
# SPI Register and Frame-Buffer Slave

This block lets an external host, acting as SPI master in mode 0, reach two storage areas inside a chip: a 64-entry file of 8-bit registers and a 128-byte buffer that holds one frame. Every transaction opens with the active-low select going low. The first byte the host sends is a command. While that command shifts in, the block shifts out a status byte taken from an input port. The command picks one of four access kinds. A register access moves a single data byte. A frame access moves a length byte and then the payload. On a frame read, one more byte carrying a link-quality value follows the payload.

The SPI pins are sampled by a faster system clock through two-flop synchronizers. MOSI is taken on the rising SCLK edge, most significant bit first. MISO is updated after each falling SCLK edge. Raising select ends the access at once, and the engine then waits for a fresh command.

Top module: `spi_fb_slave`

## Requirements
- R1: A command byte with bits [7:6] = 2'b11 is a register write to the address in bits [5:0]. The next full byte is stored in that register.
- R2: A command byte with bits [7:6] = 2'b10 is a register read of the address in bits [5:0]. The register contents are shifted out on MISO during the second byte.
- R3: During the command byte of every transaction, MISO shifts out the value of `phyStatus` as it stood when select went low.
- R4: A command byte with bits [7:5] = 3'b011 is a frame write. Byte 2 is the frame length, and the payload bytes that follow are stored at buffer positions 0, 1, 2 and onward.
- R5: A command byte with bits [7:5] = 3'b001 is a frame read. Byte 2 returns the stored length, then come that many payload bytes, then one byte equal to `linkQuality`, and every byte after that reads 0x00.
- R6: A frame length above 127 is stored as 127.
- R7: In a frame write, payload bytes beyond the length are discarded and leave the buffer unchanged.
- R8: Any other command pattern (01 with bit 5 clear, or 000) makes the block ignore all bytes until select rises.
- R9: Raising select throws away any partial byte. The next transaction starts again with a command byte.
- R10: After reset every register reads 0x00 and the stored frame length is 0.
- R11: Bits are sampled on the rising SCLK edge and sent MSB first, and MISO holds steady while SCLK is high within a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the host |
| selN | input | 1 | Active-low transaction select |
| mosi | input | 1 | Serial data from the host |
| phyStatus | input | 8 | Status byte returned during the command byte |
| linkQuality | input | 8 | Link-quality byte appended to frame reads |
| miso | output | 1 | Serial data to the host |

## Verification
Each pin passes through two synchronizer flops and one edge-detect flop. A register or buffer write therefore lands one system cycle after the block detects the eighth rising edge, about four cycles after the pin edge. MISO changes about four cycles after a falling SCLK pin edge. The bench holds every SCLK phase for eight system cycles and samples MISO on the last cycle of the low phase, after the update has settled and before the next rising edge. Write results are observed only through later read transactions, which starts them many cycles after the write has landed.

// File: rtl/spi_fb_pkg.sv
package spi_fb_pkg;
  localparam int REG_AW    = 6;
  localparam int BUF_AW    = 7;
  localparam int DW        = 8;
  localparam int BIT_W     = $clog2(DW);
  localparam int REG_COUNT = 1 << REG_AW;
  localparam int BUF_DEPTH = 1 << BUF_AW;
  localparam int MAX_LEN   = BUF_DEPTH - 1;

  typedef enum logic [2:0] {RD_ZERO, RD_REG, RD_LEN, RD_BUF, RD_LQI} rdKind_t;

  typedef struct packed {
    logic              regWe;
    logic              lenWe;
    logic              bufWe;
    logic              txLoadStatus;
    logic              txLoad;
    logic              txShift;
    rdKind_t           rdKind;
    logic [REG_AW-1:0] regAddr;
    logic [BUF_AW-1:0] bufAddr;
    logic [DW-1:0]     wData;
  } ctl_t;
endpackage

// File: rtl/spi_fb_control.sv
module spi_fb_control
  import spi_fb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              selN,
  input  logic              mosi,
  input  logic [BUF_AW-1:0] frameLen,
  output ctl_t              ctl,
  output logic              sclkLvl,
  output logic              selActive
);
  typedef enum logic [2:0] {M_CMD, M_REGW, M_REGR, M_FRW, M_FRR, M_IGN} mode_t;

  localparam logic [DW-1:0]    CNT_MAX  = '1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);

  logic [2:0]       sclkSync;
  logic [1:0]       selSync;
  logic [1:0]       mosiSync;
  logic             sclkRise, sclkFall, mosiBit, byteDone, inPayload, isLqi;
  logic [BIT_W-1:0] bitCnt;
  logic [DW-2:0]    rxShift;
  logic [DW-1:0]    rxByte, byteCnt, payIdx, lenExt;
  logic [REG_AW-1:0] addr;
  mode_t            mode;

  // pin synchronizers; sclk gets a third stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      selSync  <= 2'b11;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      selSync  <= {selSync[0], selN};
      mosiSync <= {mosiSync[0], mosi};
    end
  end

  assign sclkLvl   = sclkSync[1];
  assign sclkRise  = sclkSync[1] & ~sclkSync[2];
  assign sclkFall  = ~sclkSync[1] & sclkSync[2];
  assign selActive = ~selSync[1];
  assign mosiBit   = mosiSync[1];
  assign rxByte    = {rxShift, mosiBit};
  assign byteDone  = selActive & sclkRise & (bitCnt == LAST_BIT);

  function automatic mode_t decodeCmd(input logic [DW-1:0] c);
    if (c[7:6] == 2'b11)      return M_REGW;
    else if (c[7:6] == 2'b10) return M_REGR;
    else if (c[7:5] == 3'b011) return M_FRW;
    else if (c[7:5] == 3'b001) return M_FRR;
    else                       return M_IGN;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= M_CMD;
      bitCnt  <= '0;
      byteCnt <= '0;
      rxShift <= '0;
      addr    <= '0;
    end else if (!selActive) begin
      mode    <= M_CMD;
      bitCnt  <= '0;
      byteCnt <= '0;
      rxShift <= '0;
    end else if (sclkRise) begin
      rxShift <= rxByte[DW-2:0];
      bitCnt  <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT) begin
        if (byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
        if (mode == M_CMD) begin
          mode <= decodeCmd(rxByte);
          addr <= rxByte[REG_AW-1:0];
        end
      end
    end
  end

  // byteCnt is the 0-based index of the byte in flight: 0 command, 1 length, 2.. payload
  assign payIdx    = byteCnt - DW'(2);
  assign lenExt    = DW'(frameLen);
  assign inPayload = (byteCnt >= DW'(2)) && (payIdx < lenExt);
  assign isLqi     = (byteCnt >= DW'(2)) && (payIdx == lenExt);

  always_comb begin
    ctl              = '0;
    ctl.wData        = rxByte;
    ctl.regAddr      = addr;
    ctl.bufAddr      = payIdx[BUF_AW-1:0];
    ctl.regWe        = byteDone && (mode == M_REGW) && (byteCnt == DW'(1));
    ctl.lenWe        = byteDone && (mode == M_FRW) && (byteCnt == DW'(1));
    ctl.bufWe        = byteDone && (mode == M_FRW) && inPayload;
    ctl.txLoadStatus = !selActive;
    ctl.txLoad       = selActive && sclkFall && (bitCnt == '0) && (byteCnt != '0);
    ctl.txShift      = selActive && sclkFall && (bitCnt != '0);
    ctl.rdKind       = RD_ZERO;
    if (mode == M_REGR && byteCnt == DW'(1)) begin
      ctl.rdKind = RD_REG;
    end else if (mode == M_FRR) begin
      if (byteCnt == DW'(1)) ctl.rdKind = RD_LEN;
      else if (inPayload)    ctl.rdKind = RD_BUF;
      else if (isLqi)        ctl.rdKind = RD_LQI;
    end
  end
endmodule

// File: rtl/spi_fb_datapath.sv
module spi_fb_datapath
  import spi_fb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [DW-1:0]     phyStatus,
  input  logic [DW-1:0]     linkQuality,
  output logic              miso,
  output logic [BUF_AW-1:0] frameLen
);
  logic [DW-1:0] regFile  [REG_COUNT];
  logic [DW-1:0] frameBuf [BUF_DEPTH];
  logic [DW-1:0] txReg, nextByte;
  logic [BUF_AW-1:0] clippedLen;

  assign clippedLen = (ctl.wData > DW'(MAX_LEN)) ? BUF_AW'(MAX_LEN) : ctl.wData[BUF_AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (ctl.regWe) begin
      regFile[ctl.regAddr] <= ctl.wData;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.bufWe) frameBuf[ctl.bufAddr] <= ctl.wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          frameLen <= '0;
    else if (ctl.lenWe) frameLen <= clippedLen;
  end

  always_comb begin
    case (ctl.rdKind)
      RD_REG:  nextByte = regFile[ctl.regAddr];
      RD_LEN:  nextByte = DW'(frameLen);
      RD_BUF:  nextByte = frameBuf[ctl.bufAddr];
      RD_LQI:  nextByte = linkQuality;
      default: nextByte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 txReg <= '0;
    else if (ctl.txLoadStatus) txReg <= phyStatus;
    else if (ctl.txLoad)       txReg <= nextByte;
    else if (ctl.txShift)      txReg <= {txReg[DW-2:0], 1'b0};
  end

  assign miso = txReg[DW-1];
endmodule

// File: rtl/spi_fb_slave.sv
module spi_fb_slave
  import spi_fb_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclk,
  input  logic          selN,
  input  logic          mosi,
  input  logic [DW-1:0] phyStatus,
  input  logic [DW-1:0] linkQuality,
  output logic          miso
);
  ctl_t              ctl;
  logic [BUF_AW-1:0] frameLen;
  logic              sclkLvl, selActive;

  spi_fb_control u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .selN(selN), .mosi(mosi),
    .frameLen(frameLen), .ctl(ctl), .sclkLvl(sclkLvl), .selActive(selActive)
  );

  spi_fb_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .phyStatus(phyStatus),
    .linkQuality(linkQuality), .miso(miso), .frameLen(frameLen)
  );
endmodule

// File: rtl/spi_fb_checker.sv
module spi_fb_checker
  import spi_fb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              miso,
  input logic [DW-1:0]     phyStatus,
  input ctl_t              ctl,
  input logic [BUF_AW-1:0] frameLen,
  input logic              sclkLvl,
  input logic              selActive
);
  // R3
  status_preload_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selActive |=> miso == $past(phyStatus[DW-1]));

  // R6
  len_clip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lenWe && ctl.wData > DW'(MAX_LEN)) |=> frameLen == BUF_AW'(MAX_LEN));

  // R7
  payload_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.bufWe |-> ctl.bufAddr < frameLen);

  // R8
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.regWe, ctl.lenWe, ctl.bufWe}));

  // R11
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selActive && $past(selActive) && sclkLvl && $past(sclkLvl)) |-> $stable(miso));
endmodule

bind spi_fb_slave spi_fb_checker u_chk (
  .clk(clk), .rstN(rstN), .miso(miso), .phyStatus(phyStatus), .ctl(ctl),
  .frameLen(frameLen), .sclkLvl(sclkLvl), .selActive(selActive)
);

// File: tb/spi_fb_slave_tb.sv
module spi_fb_slave_tb;
  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, selN = 1'b1, mosi = 1'b0;
  logic [7:0] phyStatus = 8'h00, linkQuality = 8'h00;
  logic miso;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] txb [0:159];
  logic [7:0] rxb [0:159];

  always #2 clk = ~clk;

  spi_fb_slave u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .selN(selN), .mosi(mosi),
    .phyStatus(phyStatus), .linkQuality(linkQuality), .miso(miso)
  );

  // {addr[5:0], data[7:0]}
  localparam logic [13:0] VEC [6] = '{
    {6'd0, 8'h5A}, {6'd63, 8'hFF}, {6'd1, 8'h01},
    {6'd31, 8'h80}, {6'd32, 8'hA5}, {6'd17, 8'h3C}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (8) @(negedge clk);
  endtask

  task automatic shiftBit(input logic b, output logic r);
    mosi = b;
    halfWait();
    r = miso;
    sclk = 1'b1;
    halfWait();
    sclk = 1'b0;
  endtask

  task automatic spiTxn(input int n);
    logic r;
    selN = 1'b0;
    halfWait();
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        shiftBit(txb[i][b], r);
        rxb[i][b] = r;
      end
    end
    halfWait();
    selN = 1'b1;
    halfWait();
  endtask

  task automatic partialTxn(input int nbits);
    logic r;
    selN = 1'b0;
    halfWait();
    for (int k = 0; k < nbits; k++) shiftBit(txb[k/8][7-(k%8)], r);
    halfWait();
    selN = 1'b1;
    halfWait();
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [7:0] d);
    txb[0] = {2'b11, a};
    txb[1] = d;
    spiTxn(2);
    check("R3 status on reg write", rxb[0], phyStatus);
  endtask

  task automatic regRead(input logic [5:0] a, output logic [7:0] d);
    txb[0] = {2'b10, a};
    txb[1] = 8'h00;
    spiTxn(2);
    d = rxb[1];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    regRead(6'd0, d);  check("R10 reg0 after reset", d, 8'h00);
    regRead(6'd63, d); check("R10 reg63 after reset", d, 8'h00);
    linkQuality = 8'h3E;
    phyStatus = 8'hB1;
    txb[0] = 8'h20; for (int i = 1; i < 5; i++) txb[i] = 8'h00;
    spiTxn(4);
    check("R3 status on frame read", rxb[0], 8'hB1);
    check("R10 length after reset", rxb[1], 8'h00);
    check("R5 lqi after empty frame", rxb[2], 8'h3E);
    check("R5 zero after lqi", rxb[3], 8'h00);

    // R1 R2 table walk
    for (int i = 0; i < 6; i++) begin
      phyStatus = VEC[i][7:0] ^ 8'h99;
      regWrite(VEC[i][13:8], VEC[i][7:0]);
    end
    for (int i = 0; i < 6; i++) begin
      phyStatus = 8'h40 + 8'(i);
      regRead(VEC[i][13:8], d);
      check("R1 R2 R11 reg readback", d, VEC[i][7:0]);
      check("R3 status on reg read", rxb[0], 8'h40 + 8'(i));
    end

    // R4 R5 short frame
    linkQuality = 8'hC7;
    txb[0] = 8'h6A; txb[1] = 8'd5;
    for (int i = 0; i < 5; i++) txb[2+i] = 8'h11 + 8'(i);
    spiTxn(7);
    txb[0] = 8'h3F; for (int i = 1; i < 10; i++) txb[i] = 8'hFF;
    spiTxn(10);
    check("R5 length byte", rxb[1], 8'd5);
    for (int i = 0; i < 5; i++) check("R4 R5 payload", rxb[2+i], 8'h11 + 8'(i));
    check("R5 lqi byte", rxb[7], 8'hC7);
    check("R5 trailing zero", rxb[8], 8'h00);
    check("R5 trailing zero", rxb[9], 8'h00);

    // R6 clipped length, full buffer
    txb[0] = 8'h60; txb[1] = 8'd200;
    for (int i = 0; i < 130; i++) txb[2+i] = 8'(i*3 + 1);
    spiTxn(132);
    linkQuality = 8'h5D;
    txb[0] = 8'h20; for (int i = 1; i < 131; i++) txb[i] = 8'h00;
    spiTxn(131);
    check("R6 clipped length", rxb[1], 8'd127);
    for (int i = 0; i < 127; i++) check("R6 payload", rxb[2+i], 8'(i*3 + 1));
    check("R6 lqi after 127 bytes", rxb[129], 8'h5D);
    check("R5 zero after lqi", rxb[130], 8'h00);

    // R7 excess payload dropped
    txb[0] = 8'h60; txb[1] = 8'd3;
    for (int i = 0; i < 5; i++) txb[2+i] = 8'hE0 + 8'(i);
    spiTxn(7);
    txb[0] = 8'h60; txb[1] = 8'd10;
    spiTxn(2);
    txb[0] = 8'h20; for (int i = 1; i < 13; i++) txb[i] = 8'h00;
    spiTxn(13);
    check("R7 length", rxb[1], 8'd10);
    for (int i = 0; i < 3; i++) check("R7 kept bytes", rxb[2+i], 8'hE0 + 8'(i));
    for (int i = 3; i < 10; i++) check("R7 untouched bytes", rxb[2+i], 8'(i*3 + 1));
    check("R7 lqi", rxb[12], 8'h5D);

    // R8 ignored commands
    regWrite(6'd9, 8'h44);
    phyStatus = 8'h6C;
    txb[0] = 8'h49; txb[1] = 8'h12; txb[2] = 8'h34;
    spiTxn(3);
    check("R3 status on ignored command", rxb[0], 8'h6C);
    check("R8 no data out", rxb[1], 8'h00);
    txb[0] = 8'h09; txb[1] = 8'h02; txb[2] = 8'h77;
    spiTxn(3);
    regRead(6'd9, d); check("R8 reg unchanged", d, 8'h44);
    txb[0] = 8'h20; txb[1] = 8'h00;
    spiTxn(2);
    check("R8 length unchanged", rxb[1], 8'd10);

    // R9 aborted bytes
    txb[0] = 8'hC9; txb[1] = 8'h99;
    partialTxn(13);
    regRead(6'd9, d); check("R9 aborted write ignored", d, 8'h44);
    txb[0] = 8'hFF;
    partialTxn(3);
    regWrite(6'd9, 8'h66);
    regRead(6'd9, d); check("R9 resync after abort", d, 8'h66);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule